// File: doc/BRIEF.md
# 64b/66b Receive Descrambler with Sync-Header Check

This block sits in a receive lane after block alignment. Each cycle with a valid input, it takes one aligned 66-bit code word. The code word is split into a 2-bit sync header and a 64-bit scrambled payload. The payload goes through the self-synchronizing descrambler for the polynomial x^58 + x^39 + 1. The recovered 64-bit block leaves one cycle later, together with:
- a flag saying whether the block carries control or data, and
- a flag marking a block whose header is not a legal sync value.

The descrambler state is built only from received bits. A receiver that starts in an unknown state therefore produces correct output once 58 payload bits have passed. No seed exchange is needed.

A single illegal header only marks its own block as suspect. The lane error output is raised when illegal headers arrive on consecutive blocks, so one isolated bit hit on the header does not count as a lane fault. Idle cycles between blocks do not break or reset a run. Alignment search, clock recovery and the meaning of individual control type values are handled elsewhere.

Top module: `rx66_descrambler`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outValid`, `outBadHdr` and `outErr` are 0.
- R2: A block whose header field `inWord[65:64]` is 2'b01 is output with `outIsCtrl` = 0 and `outBadHdr` = 0.
- R3: A block whose header field is 2'b10 is output with `outIsCtrl` = 1 and `outBadHdr` = 0. The payload is descrambled the same way as a data block.
- R4: A block whose header field is 2'b00 or 2'b11 is output with `outBadHdr` = 1 and `outIsCtrl` = 0.
- R5: An illegal header preceded by a legal one leaves `outErr` at 0.
- R6: An illegal header on a block whose previous block also had an illegal header sets `outErr` to 1 for that block. This repeats for each further illegal block in the run.
- R7: Any legal header ends the run: the sequence illegal, legal, illegal gives `outErr` = 0 on every block.
- R8: Payload bit i is processed in order from bit 0 to bit 63. Each output bit equals the received bit XOR state bit 38 XOR state bit 57. The received bit then shifts into state bit 0.
- R9: After 58 received payload bits, the output is correct whatever the starting state was. For a block, this means bits 63..58 of the first block and all of the next block.
- R10: Each input block gives exactly one output one clock later, with `outValid` = 1. Cycles with `inValid` = 0 give `outValid` = 0 and change neither the descrambler state nor the error run.
- R11: The payload of a block with an illegal header still advances the descrambler, so the following block descrambles correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Code word present on `inWord` this cycle |
| inWord | input | 66 | Bits 65:64 sync header, bits 63:0 scrambled payload (bit 0 first on the line) |
| outValid | output | 1 | Output block valid |
| outData | output | 64 | Descrambled payload |
| outIsCtrl | output | 1 | Block carries control (header 10) |
| outBadHdr | output | 1 | Header of this block was 00 or 11 |
| outErr | output | 1 | Second or later consecutive illegal header |

## Verification
The assertions assume that `inWord` holds a word that is already aligned whenever `inValid` is high. They also assume that the stimulus changes inputs only away from the clock edge. The bench keeps to this by driving on the falling edge and pulsing `inValid` for one cycle per block.

Payloads are scrambled in the bench by its own transmit-side model. Its state starts at zero to match the reset state, except in the resynchronization scenario. There the model state is deliberately seeded differently, so the check covers only the bits that R9 guarantees.

// File: rtl/rx66_pkg.sv
package rx66_pkg;
  localparam logic [1:0] HDR_DATA = 2'b01;
  localparam logic [1:0] HDR_CTRL = 2'b10;

  typedef struct packed {
    logic load;
    logic isCtrl;
    logic badHdr;
    logic err;
  } blkStrobe_t;
endpackage

// File: rtl/rx66_ctrl.sv
module rx66_ctrl
  import rx66_pkg::*;
#(
  parameter int ERR_RUN = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inHdr,
  output blkStrobe_t strobe
);
  localparam int CNT_W = $clog2(ERR_RUN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(ERR_RUN);
  localparam logic [CNT_W-1:0] RUN_TRIP = CNT_W'(ERR_RUN - 1);

  logic [CNT_W-1:0] runCnt;
  logic hdrIllegal;

  assign hdrIllegal = (inHdr != HDR_DATA) && (inHdr != HDR_CTRL);

  always_comb begin
    strobe.load   = inValid;
    strobe.isCtrl = inValid && (inHdr == HDR_CTRL);
    strobe.badHdr = inValid && hdrIllegal;
    strobe.err    = inValid && hdrIllegal && (runCnt >= RUN_TRIP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (inValid) begin
      if (!hdrIllegal)           runCnt <= '0;
      else if (runCnt < RUN_MAX) runCnt <= runCnt + 1'b1;
    end
  end

  // R7: a legal header always empties the run counter
  a_r7_legal_clears_run: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !hdrIllegal) |=> (runCnt == '0));

  // R10: idle cycles leave the run untouched
  a_r10_idle_keeps_run: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(runCnt));
endmodule

// File: rtl/rx66_dpath.sv
module rx66_dpath
  import rx66_pkg::*;
#(
  parameter int PAY_W  = 64,
  parameter int LFSR_W = 58,
  parameter int TAP_LO = 39
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PAY_W-1:0] inPay,
  input  blkStrobe_t       strobe,
  output logic             outValid,
  output logic [PAY_W-1:0] outData,
  output logic             outIsCtrl,
  output logic             outBadHdr,
  output logic             outErr
);
  logic [LFSR_W-1:0] lfsrQ;
  logic [LFSR_W-1:0] lfsrD;
  logic [PAY_W-1:0]  plain;

  always_comb begin
    logic [LFSR_W-1:0] st;
    st = lfsrQ;
    for (int i = 0; i < PAY_W; i++) begin
      plain[i] = inPay[i] ^ st[TAP_LO-1] ^ st[LFSR_W-1];
      st = {st[LFSR_W-2:0], inPay[i]};
    end
    lfsrD = st;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ     <= '0;
      outValid  <= 1'b0;
      outData   <= '0;
      outIsCtrl <= 1'b0;
      outBadHdr <= 1'b0;
      outErr    <= 1'b0;
    end else begin
      outValid  <= strobe.load;
      outIsCtrl <= strobe.isCtrl;
      outBadHdr <= strobe.badHdr;
      outErr    <= strobe.err;
      if (strobe.load) begin
        lfsrQ   <= lfsrD;
        outData <= plain;
      end
    end
  end

  // R4: a suspect block is never flagged as control
  a_r4_bad_not_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    outBadHdr |-> !outIsCtrl);

  // R6: lane error only accompanies a suspect block
  a_r6_err_on_bad_only: assert property (@(posedge clk) disable iff (!rstN)
    outErr |-> (outBadHdr && outValid));

  // R10: one output per accepted block, one cycle later
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid);

  generate
    if (PAY_W >= LFSR_W) begin : g_selfsync
      // R9, R11: after a block the state holds only received bits
      a_r11_state_from_line: assert property (@(posedge clk) disable iff (!rstN)
        strobe.load |=> (lfsrQ[0] == $past(inPay[PAY_W-1])));
    end
  endgenerate
endmodule

// File: rtl/rx66_descrambler.sv
module rx66_descrambler
  import rx66_pkg::*;
#(
  parameter int PAY_W   = 64,
  parameter int LFSR_W  = 58,
  parameter int TAP_LO  = 39,
  parameter int ERR_RUN = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [PAY_W+1:0] inWord,
  output logic             outValid,
  output logic [PAY_W-1:0] outData,
  output logic             outIsCtrl,
  output logic             outBadHdr,
  output logic             outErr
);
  blkStrobe_t strobe;

  rx66_ctrl #(.ERR_RUN(ERR_RUN)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inHdr   (inWord[PAY_W+1:PAY_W]),
    .strobe  (strobe)
  );

  rx66_dpath #(.PAY_W(PAY_W), .LFSR_W(LFSR_W), .TAP_LO(TAP_LO)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .inPay     (inWord[PAY_W-1:0]),
    .strobe    (strobe),
    .outValid  (outValid),
    .outData   (outData),
    .outIsCtrl (outIsCtrl),
    .outBadHdr (outBadHdr),
    .outErr    (outErr)
  );
endmodule

// File: tb/sim_rx66_descrambler.sv
module sim_rx66_descrambler;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [65:0] inWord = '0;
  logic        outValid;
  logic [63:0] outData;
  logic        outIsCtrl, outBadHdr, outErr;

  int checks = 0;
  int errors = 0;
  logic [57:0] txState = '0;
  logic        prevBad = 1'b0;

  always #10 clk = ~clk;

  rx66_descrambler u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outData(outData), .outIsCtrl(outIsCtrl),
    .outBadHdr(outBadHdr), .outErr(outErr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // transmit-side scrambler model: scrambled bit feeds back into the state
  task automatic scramble(input logic [63:0] d, output logic [63:0] s);
    for (int i = 0; i < 64; i++) begin
      s[i] = d[i] ^ txState[38] ^ txState[57];
      txState = {txState[56:0], s[i]};
    end
  endtask

  task automatic sendBlock(input logic [1:0] hdr, input logic [63:0] pay,
                           input logic [63:0] mask, input string req);
    logic [63:0] scr;
    logic bad, expErr;
    scramble(pay, scr);
    bad = (hdr == 2'b00) || (hdr == 2'b11);
    expErr = bad && prevBad;
    prevBad = bad;
    @(negedge clk);
    inValid = 1'b1;
    inWord = {hdr, scr};
    @(posedge clk);
    #1;
    check({req, " valid"}, {63'b0, outValid}, 64'd1);
    check({req, " data"}, outData & mask, pay & mask);
    check({req, " ctrl"}, {63'b0, outIsCtrl}, {63'b0, hdr == 2'b10});
    check({req, " bad"}, {63'b0, outBadHdr}, {63'b0, bad});
    check({req, " err"}, {63'b0, outErr}, {63'b0, expErr});
    @(negedge clk);
    inValid = 1'b0;
    inWord = '0;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic testReset();
    #1;
    check("R1 valid in reset", {63'b0, outValid}, 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1 valid", {63'b0, outValid}, 64'd0);
    check("R1 bad", {63'b0, outBadHdr}, 64'd0);
    check("R1 err", {63'b0, outErr}, 64'd0);
  endtask

  task automatic testData();
    sendBlock(2'b01, 64'h0, '1, "R2 R8 zero");
    sendBlock(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, '1, "R2 R8 ones");
    for (int k = 0; k < 6; k++) sendBlock(2'b01, rnd64(), '1, "R2 R8 random");
  endtask

  task automatic testCtrl();
    sendBlock(2'b10, 64'h1E00_0000_0000_0000, '1, "R3 idle-like");
    sendBlock(2'b10, rnd64(), '1, "R3 random");
  endtask

  task automatic testSingleBad();
    sendBlock(2'b00, rnd64(), '1, "R4 R5 hdr00");
    sendBlock(2'b01, rnd64(), '1, "R11 after bad");
    sendBlock(2'b11, rnd64(), '1, "R4 R5 hdr11");
    sendBlock(2'b10, rnd64(), '1, "R11 ctrl after bad");
  endtask

  task automatic testDoubleBad();
    sendBlock(2'b11, rnd64(), '1, "R6 first");
    sendBlock(2'b00, rnd64(), '1, "R6 second");
    sendBlock(2'b11, rnd64(), '1, "R6 third");
    sendBlock(2'b01, rnd64(), '1, "R6 recover");
  endtask

  task automatic testBreak();
    sendBlock(2'b00, rnd64(), '1, "R7 bad");
    sendBlock(2'b10, rnd64(), '1, "R7 legal");
    sendBlock(2'b00, rnd64(), '1, "R7 bad again");
    sendBlock(2'b01, rnd64(), '1, "R7 legal end");
  endtask

  task automatic testGap();
    sendBlock(2'b11, rnd64(), '1, "R10 bad before gap");
    repeat (3) begin
      @(posedge clk);
      #1;
      check("R10 idle valid", {63'b0, outValid}, 64'd0);
    end
    sendBlock(2'b11, rnd64(), '1, "R10 R6 bad after gap");
    repeat (2) @(posedge clk);
    sendBlock(2'b01, rnd64(), '1, "R10 data after gap");
  endtask

  task automatic testResync();
    txState = {$urandom(), $urandom()} | 58'h1;
    sendBlock(2'b01, rnd64(), 64'hFC00_0000_0000_0000, "R9 first block tail");
    sendBlock(2'b01, rnd64(), '1, "R9 second block");
    sendBlock(2'b10, rnd64(), '1, "R9 third block");
  endtask

  initial begin
    testReset();
    testData();
    testCtrl();
    testSingleBad();
    testDoubleBad();
    testBreak();
    testGap();
    testResync();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule